// File: doc/BRIEF.md
# Shadow Stack Pointer Unit

This block carries out return-address protection operations for a processor core. It owns the shadow stack pointer, a register that grows toward lower addresses. Software can also load that pointer through a control-register write at address 0x011. The core hands the block one request at a time. The request is one of four operations: store a return address, load and verify a return address, read the pointer, or atomically exchange a shadow-stack memory word. Along with it come both link-register values, the enable state of the feature and the outcome of the core's privilege check.

Memory traffic goes over a single-beat port. The block raises a one-cycle request, and a response arrives on a later cycle with the previous contents of the addressed location, or with an error flag. Each operation ends with a one-cycle done pulse that carries the result value and an exception code. The pointer changes only when an operation succeeds. A stored return address goes below the current pointer, and the pointer moves down to it. A verified load moves the pointer back up. A mismatch stops the operation and raises a software-check fault. The step size is the register width in bytes.

Top module: `shstk_unit`

## Requirements
- R1: After reset, `ssp_o` is 0, and `busy_o`, `done_o` and `mem_req` are all 0.
- R2: Push (op 0) issues one write beat of link_a (sel 0) or link_b (sel 1) to address ssp-XLEN/8. When the response has no error, `done_o` pulses with exc 0 and `ssp_o` becomes that address.
- R3: Pop (op 1) issues one read beat at ssp. When the returned word equals the selected link value, exc is 0 and `ssp_o` rises by XLEN/8.
- R4: When a pop reads a word that differs from the selected link value, exc is 3 (software check) and `ssp_o` is unchanged.
- R5: A response with the error flag set ends any memory operation with exc 4, result 0 and `ssp_o` unchanged.
- R6: Read-pointer (op 2) completes with no memory beat and pulses done one cycle after acceptance. Its result is `ssp_o` when the feature is enabled and 0 when it is disabled.
- R7: With the feature disabled, push, pop and swap complete with no memory beat, exc 0, result 0, and no change to `ssp_o`.
- R8: With the pointer register absent (`csr_present`=0), push, pop and read-pointer fault with exc 5 and make no memory beat. This fault outranks `legal_code`. Swap does not depend on `csr_present`.
- R9: `legal_code` 01 faults with exc 1 (illegal) and `legal_code` 1x faults with exc 2 (virtual). Neither makes a memory beat or changes the pointer.
- R10: Swap (op 3) writes swap_wdata at swap_addr and returns the old value. With swap_word=1 the beat is 32-bit (`mem_word`=1), only bits 31:0 are written, and the result is old bits 31:0 sign-extended. A full-width swap is illegal (exc 1) unless XLEN is 64.
- R11: A control-register write at address 0x011 loads the pointer, but only when `csr_present`=1 and the unit is idle with no request in the same cycle. Writes to any other address are ignored.
- R12: `busy_o` is high from acceptance of a memory operation until done. Requests seen while busy are ignored. `mem_req` lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Operation request, accepted when idle |
| req_op | input | 2 | 0 push, 1 pop, 2 read pointer, 3 swap |
| req_sel | input | 1 | Link select: 0 link_a, 1 link_b |
| link_a | input | XLEN | First link register value |
| link_b | input | XLEN | Alternate link register value |
| swap_addr | input | XLEN | Swap target address |
| swap_wdata | input | XLEN | Swap store value |
| swap_word | input | 1 | Swap uses 32-bit form |
| ss_enable | input | 1 | Feature enabled at some level |
| csr_present | input | 1 | Pointer register implemented |
| legal_code | input | 2 | Privilege check: 00 ok, 01 illegal, 1x virtual |
| csr_wr_en | input | 1 | Control-register write strobe |
| csr_wr_addr | input | 12 | Control-register write address |
| csr_wr_data | input | XLEN | Control-register write data |
| mem_req | output | 1 | One-cycle memory beat request |
| mem_we | output | 1 | Beat stores data |
| mem_word | output | 1 | Beat is 32-bit wide |
| mem_addr | output | XLEN | Beat address |
| mem_wdata | output | XLEN | Beat store data |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_err | input | 1 | Response error |
| mem_rdata | input | XLEN | Previous contents of the location |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Operation complete pulse |
| result_o | output | XLEN | Destination value, valid with done |
| exc_o | output | 3 | Exception code, valid with done |
| ssp_o | output | XLEN | Current shadow stack pointer |

## Verification
A corrupted pointer shows up at the ports in two ways. It is visible at once on `ssp_o`. It also appears at the next push or pop as a wrong `mem_addr`, and after that as a false software-check fault or a verified load that should have failed. A wrong latched link value or operation also makes itself known at the done pulse that ends the same operation, through exc or the result. The bench keeps its own stack image and pointer and compares all of them after every operation. At the end it compares the whole memory image, so a bad store address or data value cannot hide.

// File: rtl/shstk_pkg.sv
package shstk_pkg;

    localparam int          CSR_AW       = 12;
    localparam logic [11:0] SSP_CSR_ADDR = 12'h011;

    typedef enum logic [1:0] {
        OP_PUSH  = 2'd0,
        OP_POP   = 2'd1,
        OP_RDPTR = 2'd2,
        OP_SWAP  = 2'd3
    } ss_op_e;

    typedef enum logic [2:0] {
        EXC_NONE    = 3'd0,
        EXC_ILLEGAL = 3'd1,
        EXC_VIRTUAL = 3'd2,
        EXC_SWCHECK = 3'd3,
        EXC_ACCESS  = 3'd4,
        EXC_NOCSR   = 3'd5
    } ss_exc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ss_state_e;

endpackage

// File: rtl/shstk_ptr_step.sv
module shstk_ptr_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] ssp_i,
    output logic [XLEN-1:0] ssp_dec_o,
    output logic [XLEN-1:0] ssp_inc_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    assign ssp_dec_o = ssp_i - STEP;
    assign ssp_inc_o = ssp_i + STEP;
endmodule

// File: rtl/shstk_gate.sv
module shstk_gate
    import shstk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ss_op_e      op_i,
    input  logic        swap_word_i,
    input  logic        csr_present_i,
    input  logic [1:0]  legal_code_i,
    input  logic        enable_i,
    output ss_exc_e     exc_o,
    output logic        use_mem_o
);
    logic wide_ok;

    generate
        if (XLEN == 64) begin : g_wide
            assign wide_ok = 1'b1;
        end else begin : g_narrow
            assign wide_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        exc_o = EXC_NONE;
        if (op_i != OP_SWAP && !csr_present_i) begin
            exc_o = EXC_NOCSR;
        end else if (legal_code_i == 2'b01) begin
            exc_o = EXC_ILLEGAL;
        end else if (legal_code_i[1]) begin
            exc_o = EXC_VIRTUAL;
        end else if (op_i == OP_SWAP && !swap_word_i && !wide_ok) begin
            exc_o = EXC_ILLEGAL;
        end
        use_mem_o = (exc_o == EXC_NONE) && enable_i && (op_i != OP_RDPTR);
    end
endmodule

// File: rtl/shstk_resolve.sv
module shstk_resolve
    import shstk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ss_op_e          op_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] link_i,
    input  logic [XLEN-1:0] rdata_i,
    input  logic            err_i,
    output ss_exc_e         exc_o,
    output logic [XLEN-1:0] result_o,
    output logic            commit_o
);
    logic [XLEN-1:0] word_ext;

    generate
        if (XLEN > 32) begin : g_sext
            assign word_ext = {{(XLEN-32){rdata_i[31]}}, rdata_i[31:0]};
        end else begin : g_plain
            assign word_ext = rdata_i;
        end
    endgenerate

    always_comb begin
        exc_o    = EXC_NONE;
        result_o = '0;
        commit_o = 1'b0;
        if (err_i) begin
            exc_o = EXC_ACCESS;
        end else begin
            unique case (op_i)
                OP_PUSH: commit_o = 1'b1;
                OP_POP: begin
                    if (rdata_i != link_i) exc_o    = EXC_SWCHECK;
                    else                   commit_o = 1'b1;
                end
                OP_SWAP: result_o = word_i ? word_ext : rdata_i;
                default: result_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/shstk_unit.sv
module shstk_unit
    import shstk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_sel,
    input  logic [XLEN-1:0]   link_a,
    input  logic [XLEN-1:0]   link_b,
    input  logic [XLEN-1:0]   swap_addr,
    input  logic [XLEN-1:0]   swap_wdata,
    input  logic              swap_word,
    input  logic              ss_enable,
    input  logic              csr_present,
    input  logic [1:0]        legal_code,
    input  logic              csr_wr_en,
    input  logic [CSR_AW-1:0] csr_wr_addr,
    input  logic [XLEN-1:0]   csr_wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              busy_o,
    output logic              done_o,
    output logic [XLEN-1:0]   result_o,
    output logic [2:0]        exc_o,
    output logic [XLEN-1:0]   ssp_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    typedef struct packed {
        ss_state_e       st;
        logic [XLEN-1:0] ssp;
        ss_op_e          op;
        logic [XLEN-1:0] link;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wdata;
        logic            word;
        logic            we;
        logic            done;
        ss_exc_e         exc;
        logic [XLEN-1:0] result;
    } regs_t;

    regs_t q, d;

    ss_op_e          op_in;
    ss_exc_e         gate_exc;
    logic            gate_mem;
    logic [XLEN-1:0] ssp_dec, ssp_inc;
    logic [XLEN-1:0] link_in;
    ss_exc_e         rsp_exc;
    logic [XLEN-1:0] rsp_result;
    logic            rsp_commit;

    assign op_in   = ss_op_e'(req_op);
    assign link_in = req_sel ? link_b : link_a;

    shstk_gate #(.XLEN(XLEN)) i_gate (
        .op_i          (op_in),
        .swap_word_i   (swap_word),
        .csr_present_i (csr_present),
        .legal_code_i  (legal_code),
        .enable_i      (ss_enable),
        .exc_o         (gate_exc),
        .use_mem_o     (gate_mem)
    );

    shstk_ptr_step #(.XLEN(XLEN)) i_step (
        .ssp_i     (q.ssp),
        .ssp_dec_o (ssp_dec),
        .ssp_inc_o (ssp_inc)
    );

    shstk_resolve #(.XLEN(XLEN)) i_resolve (
        .op_i     (q.op),
        .word_i   (q.word),
        .link_i   (q.link),
        .rdata_i  (mem_rdata),
        .err_i    (mem_rsp_err),
        .exc_o    (rsp_exc),
        .result_o (rsp_result),
        .commit_o (rsp_commit)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.exc    = EXC_NONE;
        d.result = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op   = op_in;
                    d.link = link_in;
                    d.word = (op_in == OP_SWAP) && swap_word;
                    if (gate_mem) begin
                        d.st = ST_REQ;
                        unique case (op_in)
                            OP_PUSH: begin
                                d.addr  = ssp_dec;
                                d.wdata = link_in;
                                d.we    = 1'b1;
                            end
                            OP_POP: begin
                                d.addr  = q.ssp;
                                d.wdata = '0;
                                d.we    = 1'b0;
                            end
                            default: begin
                                d.addr  = swap_addr;
                                d.wdata = swap_wdata;
                                d.we    = 1'b1;
                            end
                        endcase
                    end else begin
                        d.done = 1'b1;
                        d.exc  = gate_exc;
                        if (op_in == OP_RDPTR && gate_exc == EXC_NONE && ss_enable)
                            d.result = q.ssp;
                    end
                end else if (csr_wr_en && csr_present && csr_wr_addr == SSP_CSR_ADDR) begin
                    d.ssp = csr_wr_data;
                end
            end
            ST_REQ: d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.exc    = rsp_exc;
                    d.result = rsp_result;
                    if (rsp_commit && q.op == OP_PUSH) d.ssp = q.addr;
                    if (rsp_commit && q.op == OP_POP)  d.ssp = ssp_inc;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o    = (q.st != ST_IDLE);
    assign mem_req   = (q.st == ST_REQ);
    assign mem_we    = q.we;
    assign mem_word  = q.word;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign done_o    = q.done;
    assign result_o  = q.result;
    assign exc_o     = q.exc;
    assign ssp_o     = q.ssp;

    AST_REQ_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R12
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R12
    AST_FAULT_HOLDS_SSP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o != 3'd0) |-> ssp_o == $past(ssp_o)); // R4
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o == 3'd0 && q.op == OP_PUSH && $past(q.st) == ST_WAIT)
        |-> ssp_o == $past(ssp_o) - STEP); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o == 3'd0 && q.op == OP_POP && $past(q.st) == ST_WAIT)
        |-> ssp_o == $past(ssp_o) + STEP); // R3
    AST_NO_BEAT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(ss_enable)); // R7
endmodule

// File: tb/test_shstk_unit.sv
module test_shstk_unit;
    localparam int XLEN     = 64;
    localparam int CLK_PER  = 10;
    localparam int STEP     = XLEN / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_sel = 0, swap_word = 0;
    logic [1:0] req_op = 0, legal_code = 0;
    logic [63:0] link_a = 0, link_b = 0, swap_addr = 0, swap_wdata = 0;
    logic ss_enable = 1, csr_present = 1;
    logic csr_wr_en = 0;
    logic [11:0] csr_wr_addr = 0;
    logic [63:0] csr_wr_data = 0;
    logic mem_req, mem_we, mem_word;
    logic [63:0] mem_addr, mem_wdata;
    logic mem_rsp_valid = 0, mem_rsp_err = 0;
    logic [63:0] mem_rdata = 0;
    logic busy_o, done_o;
    logic [63:0] result_o, ssp_o;
    logic [2:0] exc_o;

    always #(CLK_PER/2) clk = ~clk;

    shstk_unit #(.XLEN(XLEN)) i_shstk_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .link_a(link_a), .link_b(link_b),
        .swap_addr(swap_addr), .swap_wdata(swap_wdata), .swap_word(swap_word),
        .ss_enable(ss_enable), .csr_present(csr_present), .legal_code(legal_code),
        .csr_wr_en(csr_wr_en), .csr_wr_addr(csr_wr_addr), .csr_wr_data(csr_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o), .exc_o(exc_o), .ssp_o(ssp_o)
    );

    int total = 0, bad = 0, beats = 0, rsp_lat = 1;
    logic err_next = 0, poke_req = 0, poke_csr = 0;
    logic [63:0] mem [0:255];
    logic [63:0] ref_mem [0:255];
    logic [63:0] ref_ssp = 0;

    function automatic logic [7:0] idx(input logic [63:0] a);
        return a[10:3];
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // memory responder: returns previous contents, writes unless error
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [63:0] old;
                logic [7:0] i;
                beats++;
                i = idx(mem_addr);
                old = mem[i];
                if (mem_we && !err_next) begin
                    if (mem_word) mem[i][31:0] = mem_wdata[31:0];
                    else          mem[i] = mem_wdata;
                end
                repeat (rsp_lat) @(negedge clk);
                mem_rsp_valid = 1; mem_rsp_err = err_next; mem_rdata = old;
                @(negedge clk);
                mem_rsp_valid = 0; mem_rsp_err = 0;
            end
        end
    end

    // run one operation, compute the expected outcome from the bench model and compare
    task automatic step(input string tag, input logic [1:0] op, input logic sel,
                        input logic [63:0] la, input logic [63:0] lb,
                        input logic [63:0] sa, input logic [63:0] sw, input logic wd);
        logic [63:0] e_res = 0, n_ssp = ref_ssp, link, old;
        logic [2:0] e_exc = 0;
        int e_beat = 0, b0, t = 0;
        logic got_busy;
        link = sel ? lb : la;
        if (op != 2'd3 && !csr_present) e_exc = 3'd5;
        else if (legal_code == 2'b01) e_exc = 3'd1;
        else if (legal_code[1]) e_exc = 3'd2;
        else if (!ss_enable) e_res = 0;
        else if (op == 2'd2) e_res = ref_ssp;
        else begin
            e_beat = 1;
            if (err_next) e_exc = 3'd4;
            else if (op == 2'd0) begin
                n_ssp = ref_ssp - STEP;
                ref_mem[idx(n_ssp)] = link;
            end else if (op == 2'd1) begin
                if (ref_mem[idx(ref_ssp)] != link) e_exc = 3'd3;
                else n_ssp = ref_ssp + STEP;
            end else begin
                old = ref_mem[idx(sa)];
                e_res = wd ? {{32{old[31]}}, old[31:0]} : old;
                if (wd) ref_mem[idx(sa)][31:0] = sw[31:0];
                else    ref_mem[idx(sa)] = sw;
            end
        end
        b0 = beats;
        @(negedge clk);
        req_valid = 1; req_op = op; req_sel = sel; link_a = la; link_b = lb;
        swap_addr = sa; swap_wdata = sw; swap_word = wd;
        @(negedge clk);
        req_valid = 0;
        got_busy = busy_o;
        if (busy_o && poke_req) begin
            req_valid = 1; req_op = 2'd0;
            @(negedge clk);
            req_valid = 0;
        end else if (busy_o && poke_csr) begin
            csr_wr_en = 1; csr_wr_addr = 12'h011; csr_wr_data = 64'hdead0;
            @(negedge clk);
            csr_wr_en = 0;
        end
        while (!done_o && t < 100) begin @(negedge clk); t++; end
        chk(tag, "exc", {61'd0, exc_o}, {61'd0, e_exc});
        chk(tag, "result", result_o, e_res);
        chk(tag, "beats", 64'(beats - b0), 64'(e_beat));
        chk(tag, "ssp", ssp_o, n_ssp);
        if (e_beat == 1) chk("R12", "busy during beat", {63'd0, got_busy}, 64'd1);
        ref_ssp = n_ssp;
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [63:0] v);
        @(negedge clk);
        csr_wr_en = 1; csr_wr_addr = a; csr_wr_data = v;
        @(negedge clk);
        csr_wr_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 64'h5a5a_0000_0000_0000 + 64'(i);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ssp", ssp_o, 0);
        chk("R1", "busy", {63'd0, busy_o}, 0);
        chk("R1", "done", {63'd0, done_o}, 0);
        chk("R1", "mem_req", {63'd0, mem_req}, 0);
        rst_n = 1;

        // R11 pointer load and ignored writes
        csr_write(12'h011, 64'h400); ref_ssp = 64'h400;
        chk("R11", "load", ssp_o, 64'h400);
        csr_write(12'h012, 64'h123);
        chk("R11", "other addr ignored", ssp_o, 64'h400);
        csr_present = 0; csr_write(12'h011, 64'h777); csr_present = 1;
        chk("R11", "absent ignored", ssp_o, 64'h400);

        // R2 / R3 pushes and verified pops on both links
        step("R2", 2'd0, 0, 64'h1111, 64'h2222, 0, 0, 0);
        step("R2", 2'd0, 1, 64'h3333, 64'h4444, 0, 0, 0);
        step("R3", 2'd1, 1, 64'h0, 64'h4444, 0, 0, 0);
        step("R3", 2'd1, 0, 64'h1111, 64'h0, 0, 0, 0);
        // R6 read pointer enabled and disabled
        step("R6", 2'd2, 0, 0, 0, 0, 0, 0);
        ss_enable = 0;
        step("R6", 2'd2, 0, 0, 0, 0, 0, 0);
        // R7 disabled push/pop/swap
        step("R7", 2'd0, 0, 64'h99, 0, 0, 0, 0);
        step("R7", 2'd1, 0, 64'h99, 0, 0, 0, 0);
        step("R7", 2'd3, 0, 0, 0, 64'h40, 64'h77, 0);
        ss_enable = 1;
        // R4 corrupted entry
        step("R4", 2'd0, 0, 64'hcafe, 0, 0, 0, 0);
        mem[idx(ref_ssp)] ^= 64'h10; ref_mem[idx(ref_ssp)] ^= 64'h10;
        step("R4", 2'd1, 0, 64'hcafe, 0, 0, 0, 0);
        // R5 memory errors
        err_next = 1;
        step("R5", 2'd0, 1, 0, 64'hbeef, 0, 0, 0);
        step("R5", 2'd1, 0, 64'h1, 0, 0, 0, 0);
        step("R5", 2'd3, 0, 0, 0, 64'h80, 64'h5, 0);
        err_next = 0;
        // R8 absent pointer register
        csr_present = 0;
        step("R8", 2'd0, 0, 64'h5, 0, 0, 0, 0);
        step("R8", 2'd2, 0, 0, 0, 0, 0, 0);
        legal_code = 2'b10;
        step("R8", 2'd1, 0, 64'h5, 0, 0, 0, 0);
        legal_code = 2'b00;
        step("R8", 2'd3, 0, 0, 0, 64'h88, 64'h6, 0);
        csr_present = 1;
        // R9 privilege faults
        legal_code = 2'b01; step("R9", 2'd0, 0, 64'h5, 0, 0, 0, 0);
        legal_code = 2'b10; step("R9", 2'd0, 0, 64'h5, 0, 0, 0, 0);
        legal_code = 2'b11; step("R9", 2'd2, 0, 0, 0, 0, 0, 0);
        legal_code = 2'b00;
        // R10 swaps, word form with negative low half
        mem[idx(64'h100)] = 64'h0123_4567_8000_00f0; ref_mem[idx(64'h100)] = mem[idx(64'h100)];
        step("R10", 2'd3, 0, 0, 0, 64'h100, 64'hffff_ffff_1234_5678, 1);
        step("R10", 2'd3, 0, 0, 0, 64'h100, 64'hfeed_f00d_0000_0001, 0);
        step("R10", 2'd3, 0, 0, 0, 64'h100, 64'h0, 1);
        // R12 requests and pointer writes while busy are ignored
        rsp_lat = 3;
        poke_req = 1; step("R12", 2'd0, 0, 64'habc, 0, 0, 0, 0); poke_req = 0;
        poke_csr = 1; step("R12", 2'd1, 0, 64'habc, 0, 0, 0, 0); poke_csr = 0;

        // constrained random push/pop mix
        for (int n = 0; n < 400; n++) begin
            int r = $urandom % 16;
            logic [1:0] op = (r < 7) ? 2'd0 : (r < 14) ? 2'd1 : (r == 14) ? 2'd2 : 2'd3;
            logic sel = 1'($urandom);
            logic [63:0] la = {$urandom, $urandom}, lb = {$urandom, $urandom};
            rsp_lat = 1 + ($urandom % 3);
            err_next = ($urandom % 16) == 0;
            ss_enable = ($urandom % 12) != 0;
            if (op == 2'd1 && ($urandom % 4) != 0) begin
                if (sel) lb = ref_mem[idx(ref_ssp)]; else la = ref_mem[idx(ref_ssp)];
            end
            step(op == 2'd0 ? "R2" : op == 2'd1 ? "R3" : op == 2'd2 ? "R6" : "R10",
                 op, sel, la, lb, 64'(($urandom % 256) * 8), {$urandom, $urandom}, 1'($urandom));
        end
        err_next = 0; ss_enable = 1;

        // final memory image against the model
        begin
            int diff = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diff++;
            chk("R2", "memory image mismatches", 64'(diff), 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule